// File: doc/BRIEF.md
# Interrupt Entry Controller for a Small 8-bit Core

This block accepts interrupt requests from three sources for a compact 8-bit processor core. The first is an edge on an external pin, and software picks the edge. The second is a timer event, which is an underflow or a capture. The third is a non-maskable trap that the core raises when it executes the all-zero opcode. The block keeps one control register that the core reads and writes. That register holds the global enable, the two source enables, the edge select and two pending flags. The pending flags are sticky: only software clears them.

The core signals each instruction boundary with a strobe. At that boundary the block decides whether to accept a request. Once it accepts one, it runs an entry sequence of fixed length while the core stalls on `busy`. The sequence does three things:
- It writes the saved program counter to the stack, one byte per cycle.
- It lowers the stack pointer by two.
- It tells the core to load the single shared vector.

Software finds out which maskable source fired by polling the pending flags. The block also carries out the three return operations, which move the stack pointer back up. The return that re-enables interrupts also sets the global enable.

Top module: `irq_entry_ctrl`

## Requirements
- R1: After reset the control register reads 0, `sp` equals `SP_RST`, and `busy`, `irq_ack`, `stk_we` and `pc_load` are low.
- R2: The control register uses these bit positions: bit0 is the global enable, bit1 the external enable, bit2 the timer enable, bit3 the edge select, bit4 the external pending flag and bit5 the timer pending flag. Bits 7:6 read 0. A write with `reg_we` loads all six fields.
- R3: With edge select 0, a 0→1 change on `ext_pin` sets the external pending flag, and a 1→0 change leaves it clear. With edge select 1 the roles of the two changes swap.
- R4: A `tmr_evt` cycle sets the timer pending flag. Both pending flags keep their value until software writes 0 to them. Accepting an interrupt never clears them. An event in the same cycle as a write that clears its flag leaves the flag set.
- R5: A maskable request is accepted only when all of the following hold in the same cycle:
  - `instr_done` is high.
  - The block is idle.
  - `ret_op` is 0.
  - The global enable is set.
  - One source has both its enable and its pending flag set.
- R6: `trap_op` together with `instr_done` in an idle cycle with `ret_op` 0 is accepted whatever the enables are. That entry leaves the global enable unchanged.
- R7: Accepting a maskable request clears the global enable.
- R8: `busy` is high for exactly 7 cycles, counted from the cycle after acceptance, and `irq_ack` is high in the first of them. The numbered cycles are counted from 0 at that first busy cycle:
  - Busy cycle 1 writes the low byte of the saved `pc_in` at address `sp`.
  - Busy cycle 2 writes the zero-extended high byte at `sp`-1.
  - `sp` has dropped by 2 from busy cycle 4 onward.
  - Busy cycle 6 raises `pc_load`, with `pc_vec` equal to `VECTOR`.
- R9: A nonzero `ret_op` while idle adds 2 to `sp`. The encodings are 1 for a plain return, 2 for a skip return and 3 for an interrupt return. Code 3 also sets the global enable. `ret_op` has no effect while `busy` is high.
- R10: Acceptance uses the register values from before the current cycle. A write that clears the global enable in the same cycle as `instr_done` does not block the entry.
- R11: `instr_done` and `trap_op` have no effect while `busy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ext_pin | input | 1 | External interrupt pin, already synchronised |
| tmr_evt | input | 1 | Timer underflow or capture event, one cycle |
| trap_op | input | 1 | Core executed the all-zero opcode |
| instr_done | input | 1 | Instruction boundary strobe |
| ret_op | input | 2 | Return operation: 0 none, 1 plain, 2 skip, 3 interrupt return |
| pc_in | input | PC_W | Program counter to save on entry |
| reg_we | input | 1 | Control register write enable |
| reg_wdata | input | 8 | Control register write data |
| reg_rdata | output | 8 | Control register read data |
| busy | output | 1 | Entry sequence running; the core stalls |
| irq_ack | output | 1 | First cycle of an entry |
| stk_we | output | 1 | Stack byte write strobe |
| stk_addr | output | SP_W | Stack write address |
| stk_wdata | output | 8 | Stack write data |
| sp | output | SP_W | Stack pointer |
| pc_load | output | 1 | Core loads `pc_vec` into its program counter |
| pc_vec | output | PC_W | Interrupt vector address |

## Verification
The bench builds the block with a 12-bit program counter, an 8-bit stack pointer starting at 0x6F and the vector at 0x0FF. With a 12-bit counter the pushed high byte carries four live bits.

It sweeps all 64 combinations of global enable, both source enables, both pending flags and the trap line. That sweep reaches every acceptance and masking case, and every case of how the global enable ends up after entry. Each accepted case is followed cycle by cycle through all seven busy cycles, with `instr_done`, `trap_op` and an interrupt-return request held high throughout, which checks that all three are ignored. The return kind rotates between sweep entries, so the stack pointer walks both ways.

Directed sequences then cover:
- both edge selects;
- sticky timer pending, including an event that coincides with a clearing write;
- the same-cycle race between a write that clears the global enable and acceptance.

// File: rtl/irq_pkg.sv
package irq_pkg;

    typedef enum logic [1:0] {
        RET_NONE  = 2'd0,
        RET_PLAIN = 2'd1,
        RET_SKIP  = 2'd2,
        RET_INTR  = 2'd3
    } ret_e;

    localparam int CTL_GIE     = 0;
    localparam int CTL_EXT_EN  = 1;
    localparam int CTL_TMR_EN  = 2;
    localparam int CTL_EDGE    = 3;
    localparam int CTL_EXT_PND = 4;
    localparam int CTL_TMR_PND = 5;

    localparam int ENTRY_CYCLES = 7;

    typedef struct packed {
        logic gie;
        logic ext_en;
        logic tmr_en;
        logic edge_fall;
        logic ext_pnd;
        logic tmr_pnd;
    } ctl_t;

endpackage

// File: rtl/irq_edge_det.sv
module irq_edge_det (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    input  logic edge_fall,
    output logic evt
);

    typedef struct packed {
        logic prev;
    } det_t;

    det_t det_d, det_q;

    always_comb begin
        det_d      = det_q;
        det_d.prev = pin;
        if (edge_fall) begin
            evt = det_q.prev & ~pin;
        end else begin
            evt = ~det_q.prev & pin;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            det_q <= '0;
        end else begin
            det_q <= det_d;
        end
    end

endmodule

// File: rtl/irq_ctl_reg.sv
module irq_ctl_reg
    import irq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       we,
    input  logic [7:0] wdata,
    input  logic       ext_evt,
    input  logic       tmr_evt,
    input  logic       clr_gie,
    input  logic       set_gie,
    output ctl_t       ctl,
    output logic [7:0] rdata
);

    ctl_t ctl_d, ctl_q;
    logic unused_hi;

    assign unused_hi = ^wdata[7:6];

    always_comb begin
        ctl_d = ctl_q;
        if (we) begin
            ctl_d.gie       = wdata[CTL_GIE];
            ctl_d.ext_en    = wdata[CTL_EXT_EN];
            ctl_d.tmr_en    = wdata[CTL_TMR_EN];
            ctl_d.edge_fall = wdata[CTL_EDGE];
            ctl_d.ext_pnd   = wdata[CTL_EXT_PND];
            ctl_d.tmr_pnd   = wdata[CTL_TMR_PND];
        end
        if (set_gie) begin
            ctl_d.gie = 1'b1;
        end
        if (clr_gie) begin
            ctl_d.gie = 1'b0;
        end
        ctl_d.ext_pnd = ctl_d.ext_pnd | ext_evt;
        ctl_d.tmr_pnd = ctl_d.tmr_pnd | tmr_evt;
    end

    always_comb begin
        rdata              = '0;
        rdata[CTL_GIE]     = ctl_q.gie;
        rdata[CTL_EXT_EN]  = ctl_q.ext_en;
        rdata[CTL_TMR_EN]  = ctl_q.tmr_en;
        rdata[CTL_EDGE]    = ctl_q.edge_fall;
        rdata[CTL_EXT_PND] = ctl_q.ext_pnd;
        rdata[CTL_TMR_PND] = ctl_q.tmr_pnd;
    end

    assign ctl = ctl_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq
    import irq_pkg::*;
#(
    parameter int              PC_W   = 12,
    parameter int              SP_W   = 8,
    parameter logic [SP_W-1:0] SP_RST = 8'h6F,
    parameter logic [PC_W-1:0] VECTOR = 12'h0FF
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            instr_done,
    input  logic            trap_op,
    input  logic            mask_req,
    input  logic [1:0]      ret_op,
    input  logic [PC_W-1:0] pc_in,
    output logic            busy,
    output logic            ack,
    output logic            clr_gie,
    output logic            set_gie,
    output logic            stk_we,
    output logic [SP_W-1:0] stk_addr,
    output logic [7:0]      stk_wdata,
    output logic [SP_W-1:0] sp,
    output logic            pc_load,
    output logic [PC_W-1:0] pc_vec
);

    localparam int CNT_W = $clog2(ENTRY_CYCLES);
    localparam int PAD_W = 16 - PC_W;
    localparam logic [CNT_W-1:0] C_ACK  = CNT_W'(0);
    localparam logic [CNT_W-1:0] C_LO   = CNT_W'(1);
    localparam logic [CNT_W-1:0] C_HI   = CNT_W'(2);
    localparam logic [CNT_W-1:0] C_SP   = CNT_W'(3);
    localparam logic [CNT_W-1:0] C_LAST = CNT_W'(ENTRY_CYCLES - 1);

    typedef struct packed {
        logic            active;
        logic [CNT_W-1:0] cnt;
        logic [PC_W-1:0] pc_save;
        logic [SP_W-1:0] sp;
    } seq_t;

    seq_t seq_d, seq_q;
    logic ret_any;
    logic ret_ok;
    logic take_trap;
    logic take_mask;
    logic [15:0] pc_wide;

    always_comb begin
        ret_any   = (ret_op != 2'(RET_NONE));
        ret_ok    = ret_any && !seq_q.active;
        take_trap = instr_done && !seq_q.active && !ret_any && trap_op;
        take_mask = instr_done && !seq_q.active && !ret_any && mask_req && !trap_op;

        seq_d = seq_q;
        if (take_trap || take_mask) begin
            seq_d.active  = 1'b1;
            seq_d.cnt     = C_ACK;
            seq_d.pc_save = pc_in;
        end else if (seq_q.active) begin
            if (seq_q.cnt == C_LAST) begin
                seq_d.active = 1'b0;
                seq_d.cnt    = C_ACK;
            end else begin
                seq_d.cnt = seq_q.cnt + CNT_W'(1);
            end
        end

        if (ret_ok) begin
            seq_d.sp = seq_q.sp + SP_W'(2);
        end else if (seq_q.active && seq_q.cnt == C_SP) begin
            seq_d.sp = seq_q.sp - SP_W'(2);
        end

        clr_gie = take_mask;
        set_gie = ret_ok && (ret_op == 2'(RET_INTR));
    end

    always_comb begin
        pc_wide   = {{PAD_W{1'b0}}, seq_q.pc_save};
        busy      = seq_q.active;
        ack       = seq_q.active && (seq_q.cnt == C_ACK);
        stk_we    = seq_q.active && ((seq_q.cnt == C_LO) || (seq_q.cnt == C_HI));
        stk_addr  = (seq_q.cnt == C_HI) ? (seq_q.sp - SP_W'(1)) : seq_q.sp;
        stk_wdata = (seq_q.cnt == C_HI) ? pc_wide[15:8] : pc_wide[7:0];
        pc_load   = seq_q.active && (seq_q.cnt == C_LAST);
        pc_vec    = VECTOR;
        sp        = seq_q.sp;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq_q    <= '0;
            seq_q.sp <= SP_RST;
        end else begin
            seq_q <= seq_d;
        end
    end

endmodule

// File: rtl/irq_entry_ctrl.sv
module irq_entry_ctrl
    import irq_pkg::*;
#(
    parameter int              PC_W   = 12,
    parameter int              SP_W   = 8,
    parameter logic [SP_W-1:0] SP_RST = 8'h6F,
    parameter logic [PC_W-1:0] VECTOR = 12'h0FF
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ext_pin,
    input  logic            tmr_evt,
    input  logic            trap_op,
    input  logic            instr_done,
    input  logic [1:0]      ret_op,
    input  logic [PC_W-1:0] pc_in,
    input  logic            reg_we,
    input  logic [7:0]      reg_wdata,
    output logic [7:0]      reg_rdata,
    output logic            busy,
    output logic            irq_ack,
    output logic            stk_we,
    output logic [SP_W-1:0] stk_addr,
    output logic [7:0]      stk_wdata,
    output logic [SP_W-1:0] sp,
    output logic            pc_load,
    output logic [PC_W-1:0] pc_vec
);

    ctl_t ctl;
    logic ext_evt;
    logic clr_gie;
    logic set_gie;
    logic mask_req;

    irq_edge_det u_edge (
        .clk       (clk),
        .rst_n     (rst_n),
        .pin       (ext_pin),
        .edge_fall (ctl.edge_fall),
        .evt       (ext_evt)
    );

    irq_ctl_reg u_ctl (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (reg_we),
        .wdata   (reg_wdata),
        .ext_evt (ext_evt),
        .tmr_evt (tmr_evt),
        .clr_gie (clr_gie),
        .set_gie (set_gie),
        .ctl     (ctl),
        .rdata   (reg_rdata)
    );

    assign mask_req = ctl.gie && ((ctl.ext_en && ctl.ext_pnd) || (ctl.tmr_en && ctl.tmr_pnd));

    irq_entry_seq #(
        .PC_W   (PC_W),
        .SP_W   (SP_W),
        .SP_RST (SP_RST),
        .VECTOR (VECTOR)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .instr_done (instr_done),
        .trap_op    (trap_op),
        .mask_req   (mask_req),
        .ret_op     (ret_op),
        .pc_in      (pc_in),
        .busy       (busy),
        .ack        (irq_ack),
        .clr_gie    (clr_gie),
        .set_gie    (set_gie),
        .stk_we     (stk_we),
        .stk_addr   (stk_addr),
        .stk_wdata  (stk_wdata),
        .sp         (sp),
        .pc_load    (pc_load),
        .pc_vec     (pc_vec)
    );

endmodule

// File: rtl/irq_entry_chk.sv
module irq_entry_chk #(
    parameter int SP_W = 8
) (
    input logic            clk,
    input logic            rst_n,
    input logic            busy,
    input logic            irq_ack,
    input logic            stk_we,
    input logic [SP_W-1:0] stk_addr,
    input logic [SP_W-1:0] sp,
    input logic            pc_load,
    input logic            trap_op,
    input logic            reg_we,
    input logic [1:0]      ret_op,
    input logic [7:0]      reg_rdata
);

    // R8: the high byte lands one address below the low byte, in the next cycle
    p_push_order_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (stk_we && !$past(stk_we)) |=> (stk_we && stk_addr == $past(stk_addr) - SP_W'(1)));

    p_load_ends_r8: assert property (@(posedge clk) disable iff (!rst_n)
        pc_load |=> !busy);

    p_ack_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        irq_ack |-> busy);

    p_trap_keeps_gie_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(busy) && $past(trap_op) && !$past(reg_we)) |-> (reg_rdata[0] == $past(reg_rdata[0])));

    p_mask_clears_gie_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(busy) && !$past(trap_op)) |-> !reg_rdata[0]);

    p_ret_sp_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_op != 2'd0 && !busy) |=> (sp == $past(sp) + SP_W'(2)));

    p_reti_gie_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_op == 2'd3 && !busy) |=> reg_rdata[0]);

    p_ext_pend_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rdata[4] && !reg_we) |=> reg_rdata[4]);

    p_tmr_pend_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rdata[5] && !reg_we) |=> reg_rdata[5]);

endmodule

bind irq_entry_ctrl irq_entry_chk #(.SP_W(SP_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy      (busy),
    .irq_ack   (irq_ack),
    .stk_we    (stk_we),
    .stk_addr  (stk_addr),
    .sp        (sp),
    .pc_load   (pc_load),
    .trap_op   (trap_op),
    .reg_we    (reg_we),
    .ret_op    (ret_op),
    .reg_rdata (reg_rdata)
);

// File: tb/irq_entry_ctrl_tb.sv
module irq_entry_ctrl_tb;

    localparam int PC_W = 12;
    localparam int SP_W = 8;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            ext_pin = 1'b0;
    logic            tmr_evt = 1'b0;
    logic            trap_op = 1'b0;
    logic            instr_done = 1'b0;
    logic [1:0]      ret_op = 2'd0;
    logic [PC_W-1:0] pc_in = '0;
    logic            reg_we = 1'b0;
    logic [7:0]      reg_wdata = '0;
    logic [7:0]      reg_rdata;
    logic            busy;
    logic            irq_ack;
    logic            stk_we;
    logic [SP_W-1:0] stk_addr;
    logic [7:0]      stk_wdata;
    logic [SP_W-1:0] sp;
    logic            pc_load;
    logic [PC_W-1:0] pc_vec;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    logic [SP_W-1:0] exp_sp;

    irq_entry_ctrl #(
        .PC_W   (PC_W),
        .SP_W   (SP_W),
        .SP_RST (8'h6F),
        .VECTOR (12'h0FF)
    ) u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .ext_pin    (ext_pin),
        .tmr_evt    (tmr_evt),
        .trap_op    (trap_op),
        .instr_done (instr_done),
        .ret_op     (ret_op),
        .pc_in      (pc_in),
        .reg_we     (reg_we),
        .reg_wdata  (reg_wdata),
        .reg_rdata  (reg_rdata),
        .busy       (busy),
        .irq_ack    (irq_ack),
        .stk_we     (stk_we),
        .stk_addr   (stk_addr),
        .stk_wdata  (stk_wdata),
        .sp         (sp),
        .pc_load    (pc_load),
        .pc_vec     (pc_vec)
    );

    always #5 clk = ~clk;

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] v);
        reg_we    = 1'b1;
        reg_wdata = v;
        tick();
        reg_we    = 1'b0;
    endtask

    // Runs busy cycles 1..6 and the first idle cycle, with instr_done, trap_op
    // and an interrupt return held high to show they are ignored (R9, R11).
    task automatic follow_entry(input logic [PC_W-1:0] pc);
        instr_done = 1'b1;
        trap_op    = 1'b1;
        ret_op     = 2'd3;
        for (int k = 1; k <= 6; k++) begin
            tick();
            check(busy == 1'b1, "R8 busy", int'(busy), 1);
            check(irq_ack == 1'b0, "R8 ack", int'(irq_ack), 0);
            if (k == 1) begin
                check(stk_we && stk_addr == exp_sp && stk_wdata == pc[7:0],
                      "R8 low byte push", {stk_we, stk_addr, stk_wdata}, {1'b1, exp_sp, pc[7:0]});
            end else if (k == 2) begin
                check(stk_we && stk_addr == exp_sp - 8'd1 && stk_wdata == {4'h0, pc[11:8]},
                      "R8 high byte push", {stk_we, stk_addr, stk_wdata},
                      {1'b1, exp_sp - 8'd1, 4'h0, pc[11:8]});
            end else begin
                check(stk_we == 1'b0, "R8 no stray push", int'(stk_we), 0);
            end
            if (k >= 4) begin
                check(sp == exp_sp - 8'd2, "R8 sp lowered, R9 return ignored while busy", sp, exp_sp - 8'd2);
            end else begin
                check(sp == exp_sp, "R8 sp before decrement", sp, exp_sp);
            end
            if (k == 6) begin
                check(pc_load && pc_vec == 12'h0FF, "R8 vector load", {pc_load, pc_vec}, {1'b1, 12'h0FF});
            end else begin
                check(pc_load == 1'b0, "R8 no early load", int'(pc_load), 0);
            end
        end
        instr_done = 1'b0;
        trap_op    = 1'b0;
        ret_op     = 2'd0;
        tick();
        check(busy == 1'b0, "R11 entry ends after 7 cycles, boundary strobes ignored", int'(busy), 0);
        exp_sp = exp_sp - 8'd2;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc == 150000) begin
            checks++;
            fails++;
            $display("FAIL watchdog (all requirements): actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        exp_sp = 8'h6F;
        tick();
        tick();
        tick();
        // R1: reset state
        check(reg_rdata == 8'h00, "R1 register reset", reg_rdata, 0);
        check(sp == 8'h6F, "R1 sp reset", sp, 8'h6F);
        check(!busy && !irq_ack && !stk_we && !pc_load, "R1 outputs idle",
              {busy, irq_ack, stk_we, pc_load}, 0);
        rst_n = 1'b1;
        tick();

        // R2: layout readback (bits 7:6 always read 0)
        wr(8'hFF);
        check(reg_rdata == 8'h3F, "R2 write all ones", reg_rdata, 8'h3F);
        wr(8'h15);
        check(reg_rdata == 8'h15, "R2 write pattern", reg_rdata, 8'h15);
        wr(8'h00);

        // Sweep of enables, pending flags and trap line (R5, R6, R7, R4, R9)
        for (int c = 0; c < 64; c++) begin
            logic g, ee, te, ep, tp, tr, take;
            logic [7:0]      val;
            logic [PC_W-1:0] pc;
            logic [1:0]      rk;
            g  = c[0]; ee = c[1]; te = c[2]; ep = c[3]; tp = c[4]; tr = c[5];
            val  = {2'b00, tp, ep, 1'b0, te, ee, g};
            take = tr | (g & ((ee & ep) | (te & tp)));
            pc   = PC_W'(12'h100 + c * 37);
            wr(val);
            pc_in      = pc;
            trap_op    = tr;
            instr_done = 1'b1;
            tick();
            instr_done = 1'b0;
            trap_op    = 1'b0;
            check(busy == take, tr ? "R6 trap acceptance" : "R5 maskable acceptance", int'(busy), int'(take));
            if (take) begin
                check(irq_ack == 1'b1, "R8 ack first cycle", int'(irq_ack), 1);
                follow_entry(pc);
                check(reg_rdata[0] == (tr ? g : 1'b0), tr ? "R6 trap keeps enable" : "R7 enable cleared",
                      int'(reg_rdata[0]), int'(tr ? g : 1'b0));
                check(reg_rdata[5:4] == {tp, ep}, "R4 pending kept after entry", reg_rdata[5:4], {tp, ep});
                rk = 2'((c % 3) + 1);
                ret_op = rk;
                tick();
                ret_op = 2'd0;
                exp_sp = exp_sp + 8'd2;
                check(sp == exp_sp, "R9 return raises sp", sp, exp_sp);
                if (rk == 2'd3) begin
                    check(reg_rdata[0] == 1'b1, "R9 interrupt return sets enable", int'(reg_rdata[0]), 1);
                end else begin
                    check(reg_rdata[0] == (tr ? g : 1'b0), "R9 plain return keeps enable",
                          int'(reg_rdata[0]), int'(tr ? g : 1'b0));
                end
            end else begin
                check(reg_rdata == val, "R5 no acceptance leaves register", reg_rdata, val);
                check(sp == exp_sp, "R5 sp unchanged", sp, exp_sp);
            end
        end

        // R3: external edge selection
        wr(8'h00);
        ext_pin = 1'b1; tick();
        check(reg_rdata[4] == 1'b1, "R3 rising edge sets pending", int'(reg_rdata[4]), 1);
        wr(8'h00);
        ext_pin = 1'b0; tick();
        check(reg_rdata[4] == 1'b0, "R3 falling edge ignored with select 0", int'(reg_rdata[4]), 0);
        wr(8'h08);
        ext_pin = 1'b1; tick();
        check(reg_rdata[4] == 1'b0, "R3 rising edge ignored with select 1", int'(reg_rdata[4]), 0);
        ext_pin = 1'b0; tick();
        check(reg_rdata[4] == 1'b1, "R3 falling edge sets pending", int'(reg_rdata[4]), 1);

        // R4: timer pending is sticky; an event wins over a clearing write
        wr(8'h00);
        tmr_evt = 1'b1; tick(); tmr_evt = 1'b0;
        check(reg_rdata[5] == 1'b1, "R4 timer event sets pending", int'(reg_rdata[5]), 1);
        tick(); tick();
        check(reg_rdata[5] == 1'b1, "R4 timer pending held", int'(reg_rdata[5]), 1);
        tmr_evt = 1'b1; wr(8'h00); tmr_evt = 1'b0;
        check(reg_rdata[5] == 1'b1, "R4 event beats clearing write", int'(reg_rdata[5]), 1);
        wr(8'h00);
        check(reg_rdata[5] == 1'b0, "R4 software clear", int'(reg_rdata[5]), 0);

        // R5: a return in the acceptance cycle blocks entry
        wr(8'h13);
        instr_done = 1'b1; ret_op = 2'd1;
        tick();
        instr_done = 1'b0; ret_op = 2'd0;
        exp_sp = exp_sp + 8'd2;
        check(busy == 1'b0, "R5 return blocks acceptance", int'(busy), 0);
        check(sp == exp_sp, "R9 idle return raises sp", sp, exp_sp);

        // R10: clearing write in the same cycle as the boundary still enters
        wr(8'h13);
        pc_in = 12'hA5C;
        reg_we = 1'b1; reg_wdata = 8'h12; instr_done = 1'b1;
        tick();
        reg_we = 1'b0; instr_done = 1'b0;
        check(busy == 1'b1, "R10 race still accepted", int'(busy), 1);
        follow_entry(12'hA5C);
        check(reg_rdata[0] == 1'b0, "R10 enable ends clear", int'(reg_rdata[0]), 0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule